// File: doc/BRIEF.md
# Fractional Ratio Divider (Sequential, Restoring)

The block takes two unsigned 24-bit operands, a dividend and a divisor, where the divisor is known to be no smaller than the dividend. It returns their ratio as a fixed-point value with a one-bit integer part and a 12-bit binary fraction. Twelve fraction bits give better than three decimal places of precision. The integer bit is set only when the operands are equal.

The computation is clocked. One compare-and-subtract settles the integer part when the operands are taken in. A restoring shift-and-subtract loop then produces one fraction bit per clock, most significant bit first.

Operands enter through a valid/ready pair. `in_ready` is low for the whole computation, and the upstream side must hold `in_valid` and the operands until it sees `in_ready` high at a clock edge. A valid presented while `in_ready` is low is dropped, not queued. The result side has no back-pressure. `out_valid` is a one-cycle pulse, and the quotient stays on its port until the next result is delivered.

Top module: `ratio_frac_div`

## Requirements
- R1: After synchronous reset, `busy`, `out_valid`, `err`, `q_int` and `q_frac` are 0 and `in_ready` is 1.
- R2: An operand pair is accepted at a rising edge where `in_valid` and `in_ready` are both high. `busy` is high from the next cycle. `in_ready` stays low until the result is delivered.
- R3: `in_valid` presented while `busy` is high is ignored. It changes neither the pending result nor its timing, and it produces no further result.
- R4: `out_valid` is high for exactly one cycle. It is raised by the 12th rising edge after the accepting edge. `busy` falls at the same edge.
- R5: For divisor > 0 and dividend <= divisor, the 13-bit value {`q_int`,`q_frac`} equals floor(dividend * 4096 / divisor). `q_frac` bit 11 carries weight 1/2.
- R6: Equal non-zero operands give `q_int` = 1 and `q_frac` = 0.
- R7: A zero dividend with a non-zero divisor gives {`q_int`,`q_frac`} = 0.
- R8: A zero dividend with a zero divisor gives a zero quotient. `err` is high for that one cycle together with `out_valid`, and `err` is 0 for every other result.
- R9: `q_int` and `q_frac` change only in a cycle where `out_valid` is high. Otherwise they hold their value.
- R10: Boundary ratios are exact: dividend 1 over divisor 0xFFFFFF gives 0, and 0xFFFFFE over 0xFFFFFF gives 4095.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand pair presented |
| in_ready | output | 1 | Block can take an operand pair |
| dividend | input | 24 | Unsigned numerator |
| divisor | input | 24 | Unsigned denominator, not smaller than the numerator |
| busy | output | 1 | Computation in progress |
| out_valid | output | 1 | One-cycle result strobe |
| q_int | output | 1 | Integer bit of the ratio |
| q_frac | output | 12 | Fraction bits of the ratio, MSB weight 1/2 |
| err | output | 1 | Zero-over-zero flag, pulsed with out_valid |

## Verification
Each result is due exactly 12 rising edges after the edge that accepts its operands. The bench drives on falling edges and counts edges from the accepting one. It checks that `out_valid` stays low and `busy` stays high after each of the first 11 edges, and then samples the quotient, `err` and `out_valid` just after the 12th edge. One edge later it confirms that the strobe has dropped and the quotient has held. In the ignored-start scenario the stray `in_valid` falls inside that counted window. Twenty more idle cycles are then watched for any extra strobe.

// File: rtl/ratio_pkg.sv
package ratio_pkg;
  localparam int unsigned OP_W   = 24;
  localparam int unsigned FRAC_W = 12;
endpackage

// File: rtl/ratio_step.sv
module ratio_step #(
  parameter int unsigned W = 24
) (
  input  logic [W-1:0] rem_in,
  input  logic [W-1:0] den,
  output logic [W-1:0] rem_out,
  output logic         q_bit
);
  logic [W:0] shifted;

  assign shifted = {rem_in, 1'b0};
  assign q_bit   = (shifted >= {1'b0, den});
  assign rem_out = q_bit ? W'(shifted - {1'b0, den}) : shifted[W-1:0];
endmodule

// File: rtl/ratio_seq.sv
module ratio_seq #(
  parameter int unsigned STEPS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  output logic busy,
  output logic last,
  output logic done
);
  localparam int unsigned CW = (STEPS > 1) ? $clog2(STEPS) : 1;

  logic [CW-1:0] cnt;

  assign last = busy && (cnt == CW'(STEPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
    end else begin
      done <= last;
      if (accept) begin
        busy <= 1'b1;
        cnt  <= '0;
      end else if (last) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R4
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy)); // R4
  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy); // R2
endmodule

// File: rtl/ratio_frac_div.sv
module ratio_frac_div
  import ratio_pkg::*;
#(
  parameter int unsigned W  = OP_W,
  parameter int unsigned FB = FRAC_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  dividend,
  input  logic [W-1:0]  divisor,
  output logic          busy,
  output logic          out_valid,
  output logic          q_int,
  output logic [FB-1:0] q_frac,
  output logic          err
);
  logic          accept;
  logic          last;
  logic [W-1:0]  rem_q;
  logic [W-1:0]  den_q;
  logic [W-1:0]  rem_nx;
  logic          bit_nx;
  logic [FB-1:0] acc_q;
  logic          int_q;
  logic          zero_q;

  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  ratio_seq #(.STEPS(FB)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .busy   (busy),
    .last   (last),
    .done   (out_valid)
  );

  ratio_step #(.W(W)) u_step (
    .rem_in  (rem_q),
    .den     (den_q),
    .rem_out (rem_nx),
    .q_bit   (bit_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      den_q  <= '0;
      acc_q  <= '0;
      int_q  <= 1'b0;
      zero_q <= 1'b0;
      q_int  <= 1'b0;
      q_frac <= '0;
      err    <= 1'b0;
    end else begin
      err <= last && zero_q;
      if (accept) begin
        den_q  <= divisor;
        acc_q  <= '0;
        zero_q <= (divisor == '0);
        int_q  <= (dividend >= divisor) && (divisor != '0);
        rem_q  <= (dividend >= divisor) ? '0 : dividend;
      end else if (busy) begin
        rem_q <= rem_nx;
        acc_q <= {acc_q[FB-2:0], bit_nx};
        if (last) begin
          q_int  <= int_q && !zero_q;
          q_frac <= zero_q ? '0 : {acc_q[FB-2:0], bit_nx};
        end
      end
    end
  end

  AST_REM_BELOW_DEN: assert property (@(posedge clk) disable iff (rst)
    (busy && !zero_q) |-> (rem_q < den_q)); // R5
  AST_INT_HAS_NO_FRAC: assert property (@(posedge clk) disable iff (rst)
    (out_valid && q_int) |-> (q_frac == '0)); // R6
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    err |-> (out_valid && !q_int && q_frac == '0)); // R8
  AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable({q_int, q_frac})); // R9
  AST_OPERANDS_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy && !accept) |=> $stable(den_q)); // R3
endmodule

// File: tb/sim_ratio_frac_div.sv
module sim_ratio_frac_div;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] dividend = '0;
  logic [23:0] divisor = '0;
  logic        busy;
  logic        out_valid;
  logic        q_int;
  logic [11:0] q_frac;
  logic        err;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 0;

  always #5 clk = ~clk;

  ratio_frac_div u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .dividend(dividend), .divisor(divisor), .busy(busy),
    .out_valid(out_valid), .q_int(q_int), .q_frac(q_frac), .err(err)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Drives one pair, optionally pokes a stray start mid-flight, checks timing and value.
  task automatic run_pair(input logic [23:0] a, input logic [23:0] b,
                          input bit stray, input string req);
    longint exp;
    logic [12:0] got;
    exp = (b == 0) ? 0 : (longint'(a) * 4096) / longint'(b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; dividend = a; divisor = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 1; i <= 11; i++) begin
      if (stray && i == 4) begin
        in_valid = 1'b1; dividend = 24'd5; divisor = 24'd7;
      end
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check("R4 no early strobe", out_valid, 0);
      check("R2 busy held", busy, 1);
      check("R2 ready low", in_ready, 0);
    end
    @(posedge clk);
    @(negedge clk);
    got = {q_int, q_frac};
    check("R4 strobe at 12th edge", out_valid, 1);
    check("R4 busy falls", busy, 0);
    check({req, " quotient"}, got, exp);
    check("R8 err flag", err, (a == 0 && b == 0) ? 1 : 0);
    @(posedge clk);
    @(negedge clk);
    check("R4 strobe one cycle", out_valid, 0);
    check("R8 err drops", err, 0);
    check("R9 quotient holds", {q_int, q_frac}, got);
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 out_valid", out_valid, 0);
    check("R1 err", err, 0);
    check("R1 quotient", {q_int, q_frac}, 0);
    check("R1 in_ready", in_ready, 1);
  endtask

  task automatic t_equal();
    run_pair(24'd12345, 24'd12345, 0, "R6");
    check("R6 int bit", q_int, 1);
    run_pair(24'hFFFFFF, 24'hFFFFFF, 0, "R6");
  endtask

  task automatic t_zero();
    run_pair(24'd0, 24'd999, 0, "R7");
    run_pair(24'd0, 24'd0, 0, "R8");
  endtask

  task automatic t_bounds();
    run_pair(24'd1, 24'hFFFFFF, 0, "R10");
    run_pair(24'hFFFFFE, 24'hFFFFFF, 0, "R10");
    run_pair(24'd40, 24'd50, 0, "R5");
  endtask

  task automatic t_stray();
    run_pair(24'd3, 24'd9, 1, "R3");
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R3 no extra result", out_valid, 0);
      check("R3 stays idle", busy, 0);
    end
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      logic [23:0] b, a;
      b = 24'($urandom);
      if (b == 0) b = 24'd1;
      a = 24'(longint'($urandom) % (longint'(b) + 1));
      run_pair(a, b, 0, "R5");
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_equal();
    t_zero();
    t_bounds();
    t_stray();
    t_random();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule